// File: doc/BRIEF.md
# Event Voxel Grid Encoder

This block turns a stream of timestamped sensor events into fixed-size frames of spike input for a spiking network. Each event gives a timestamp, a column, a row and a polarity bit. The timestamp axis is cut into aligned windows of fixed length, and each window is split evenly into time bins. An accepted event sets one bit in an on-chip bit memory. The bit is picked by the event's time bin, its polarity, its row and its column. A bit that is already set stays set, so the frame records whether any event occurred and not how many.

The first in-range event after reset opens a window. A later in-range event whose timestamp lies at or beyond the end of the open window closes that window. The block then stops taking input and streams the whole tensor out, one bit per beat, over a valid/ready handshake. Each bit is cleared as it leaves. The closing event stays on the input until the stream ends and then becomes the first event of the new window. Events whose coordinates fall outside the sensor area are accepted and thrown away, and a saturating counter records them.

Top module: `voxel_event_encoder`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `drop_count` is 0.
- R2: An accepted in-range event sets voxel bit index ((bin·2 + pol)·SENSOR_H + y)·SENSOR_W + x. Here bin = ((ts − window_start) mod 2^WIN_LOG2) >> (WIN_LOG2 − BIN_LOG2). With the defaults a window is 16 ticks long and holds 4 bins of 4 ticks each.
- R3: The first in-range event after reset opens a window whose start is its timestamp with the low WIN_LOG2 bits cleared.
- R4: Several events that map to the same voxel give a single 1 bit in the output.
- R5: An in-range event with ts − window_start ≥ 2^WIN_LOG2 sees `in_ready` low. The readout starts on the next clock. Once the readout ends, that event is accepted into a new window whose start is its timestamp with the low WIN_LOG2 bits cleared.
- R6: A readout carries exactly BINS·2·SENSOR_H·SENSOR_W beats in voxel index order: time bin outermost, then polarity, then row, then column. `out_last` is high on the final beat only.
- R7: An event with x ≥ SENSOR_W or y ≥ SENSOR_H is accepted and sets no bit. It neither opens nor closes a window, whatever its timestamp. It adds 1 to `drop_count`, which saturates at 2^CNT_W − 1.
- R8: `in_ready` is 0 while `out_valid` is 1. While `out_ready` is 0, `out_valid` and `out_bit` hold their values.
- R9: Each voxel is cleared as it is read out, so no bit from a closed window appears in the next window's readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Event present |
| in_ready | output | 1 | Event accepted this cycle when high together with in_valid |
| in_ts | input | TS_W | Event timestamp, non-decreasing |
| in_x | input | X_W | Event column |
| in_y | input | Y_W | Event row |
| in_pol | input | 1 | Event polarity |
| out_valid | output | 1 | Voxel bit present |
| out_ready | input | 1 | Consumer takes the voxel bit |
| out_bit | output | 1 | Voxel value |
| out_last | output | 1 | Final voxel of the tensor |
| drop_count | output | CNT_W | Saturating count of out-of-area events |

## Verification
An accepted event sets its bit at the clock edge where it is accepted. That bit becomes visible only during the next readout. A closing event drops `in_ready` in the same cycle it is presented, and `out_valid` rises after one clock edge. Each output beat depends combinationally on the read pointer, which moves one step per handshake edge. `drop_count` changes at the edge where the dropped event is accepted. The bench drives inputs on the falling edge and samples 1 time unit later, and it holds `out_ready` low across a few edges to confirm that the data holds.

// File: rtl/vox_pkg.sv
// Shared types for the voxel encoder.
package vox_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,   // no window open yet
        ST_COLLECT = 2'd1,   // window open, accepting events
        ST_DRAIN   = 2'd2    // streaming and clearing the tensor
    } enc_state_t;
endpackage

// File: rtl/vox_event_map.sv
// Maps one event to a voxel address and classifies it.
// Assumes: timestamps non-decreasing; BIN_LOG2 <= WIN_LOG2; BIN_LOG2 >= 1.
module vox_event_map #(
    parameter int TS_W     = 16,
    parameter int X_W      = 3,
    parameter int Y_W      = 3,
    parameter int SENSOR_W = 4,
    parameter int SENSOR_H = 4,
    parameter int WIN_LOG2 = 4,
    parameter int BIN_LOG2 = 2,
    parameter int ADDR_W   = 7
) (
    input  logic [TS_W-1:0]   ts,
    input  logic [X_W-1:0]    x,
    input  logic [Y_W-1:0]    y,
    input  logic              pol,
    input  logic [TS_W-1:0]   base,
    output logic              in_range,
    output logic              late,
    output logic [ADDR_W-1:0] addr
);
    localparam int SHIFT = WIN_LOG2 - BIN_LOG2;
    localparam logic [TS_W-1:0] WIN_MASK = TS_W'((1 << WIN_LOG2) - 1);
    localparam logic [X_W:0] X_LIM = (X_W+1)'(SENSOR_W);
    localparam logic [Y_W:0] Y_LIM = (Y_W+1)'(SENSOR_H);

    logic [TS_W-1:0]     diff;
    logic [BIN_LOG2-1:0] bin;

    // Offset inside the window, bin, lateness, range and flat address.
    always_comb begin
        diff     = ts - base;
        late     = (diff & ~WIN_MASK) != '0;
        bin      = BIN_LOG2'((diff & WIN_MASK) >> SHIFT);
        in_range = ({1'b0, x} < X_LIM) && ({1'b0, y} < Y_LIM);
        addr     = ADDR_W'(((int'(bin) * 2 + int'(pol)) * SENSOR_H + int'(y))
                           * SENSOR_W + int'(x));
    end
endmodule

// File: rtl/vox_bit_store.sv
// One-bit-per-voxel memory with a set port, a clear port and one read port.
// Assumes: set and clear are never requested in the same cycle.
module vox_bit_store #(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    logic [DEPTH-1:0] mem;

    // Set or clear one voxel per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            if (clr_en) mem[clr_addr] <= 1'b0;
            if (set_en) mem[set_addr] <= 1'b1;
        end
    end

    // Read the addressed voxel.
    assign rd_bit = mem[rd_addr];

    // R2
    set_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));
    // R9
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && (rd_addr == clr_addr) |=> mem[$past(clr_addr)] == 1'b0);
endmodule

// File: rtl/vox_drain_ctr.sv
// Read pointer for the readout: walks every voxel index once, then wraps.
module vox_drain_ctr #(
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    // Advance on each accepted beat, wrap after the final voxel.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr <= '0;
        else if (step)  addr <= last ? '0 : addr + 1'b1;
    end

    assign last = (addr == LAST_IDX);

    // R6
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && last |=> addr == '0);
    // R6
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !last |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/voxel_event_encoder.sv
// Top of the event voxel encoder. Holds the window state machine, the
// window start register and the drop counter, and ties together the mapper,
// the bit store and the readout pointer.
// Assumes: in_ts never decreases; a refused event stays on the input.
module voxel_event_encoder
    import vox_pkg::*;
#(
    parameter int TS_W     = 16,
    parameter int X_W      = 3,
    parameter int Y_W      = 3,
    parameter int SENSOR_W = 4,
    parameter int SENSOR_H = 4,
    parameter int WIN_LOG2 = 4,
    parameter int BIN_LOG2 = 2,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TS_W-1:0]  in_ts,
    input  logic [X_W-1:0]   in_x,
    input  logic [Y_W-1:0]   in_y,
    input  logic             in_pol,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_bit,
    output logic             out_last,
    output logic [CNT_W-1:0] drop_count
);
    localparam int BINS   = 1 << BIN_LOG2;
    localparam int DEPTH  = BINS * 2 * SENSOR_H * SENSOR_W;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [TS_W-1:0] WIN_MASK = TS_W'((1 << WIN_LOG2) - 1);

    enc_state_t        state;
    logic [TS_W-1:0]   win_start;
    logic [TS_W-1:0]   ev_base;
    logic [TS_W-1:0]   ev_aligned;
    logic              ev_in_range;
    logic              ev_late;
    logic [ADDR_W-1:0] ev_addr;
    logic              accept;
    logic              close_win;
    logic              beat;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_last;
    logic              rd_bit;

    // Window start for this event: its own aligned base while idle.
    always_comb begin
        ev_aligned = in_ts & ~WIN_MASK;
        ev_base    = (state == ST_IDLE) ? ev_aligned : win_start;
    end

    vox_event_map #(
        .TS_W(TS_W), .X_W(X_W), .Y_W(Y_W),
        .SENSOR_W(SENSOR_W), .SENSOR_H(SENSOR_H),
        .WIN_LOG2(WIN_LOG2), .BIN_LOG2(BIN_LOG2), .ADDR_W(ADDR_W)
    ) u_map (
        .ts(in_ts), .x(in_x), .y(in_y), .pol(in_pol), .base(ev_base),
        .in_range(ev_in_range), .late(ev_late), .addr(ev_addr)
    );

    // Handshake decode: refuse a closing event and everything during drain.
    always_comb begin
        close_win = (state == ST_COLLECT) && in_valid && ev_in_range && ev_late;
        in_ready  = (state != ST_DRAIN) && !close_win;
        accept    = in_valid && in_ready;
        out_valid = (state == ST_DRAIN);
        out_bit   = rd_bit;
        out_last  = out_valid && rd_last;
        beat      = out_valid && out_ready;
    end

    // Window state machine and window start register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            win_start <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept && ev_in_range) begin
                    state     <= ST_COLLECT;
                    win_start <= ev_aligned;
                end
                ST_COLLECT: if (close_win) begin
                    state     <= ST_DRAIN;
                    win_start <= ev_aligned;
                end
                ST_DRAIN: if (beat && rd_last) state <= ST_COLLECT;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Saturating count of out-of-area events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_count <= '0;
        else if (accept && !ev_in_range && (drop_count != '1))
            drop_count <= drop_count + 1'b1;
    end

    vox_bit_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .set_en(accept && ev_in_range), .set_addr(ev_addr),
        .clr_en(beat), .clr_addr(rd_addr),
        .rd_addr(rd_addr), .rd_bit(rd_bit)
    );

    vox_drain_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .step(beat),
        .addr(rd_addr), .last(rd_last)
    );

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last));
    // R8
    drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R5
    close_starts_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready && !out_valid |=> out_valid);
    // R6
    last_ends_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);
    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !ev_in_range && (drop_count != '1)
        |=> drop_count == $past(drop_count) + 1'b1);
endmodule

// File: tb/voxel_event_encoder_bench.sv
module voxel_event_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4 * 2 * 4 * 4;
    localparam int NV         = 10;
    // Event table: timestamp, column, row, polarity.
    localparam int V_TS [NV] = '{35, 40, 44, 47, 47, 60, 70, 79, 79, 200};
    localparam int V_X  [NV] = '{ 1,  0,  3,  3,  5,  1,  2,  0,  1,   0};
    localparam int V_Y  [NV] = '{ 2,  0,  3,  3,  0,  4,  1,  3,  2,   0};
    localparam int V_P  [NV] = '{ 1,  0,  1,  1,  0,  0,  0,  1,  1,   0};

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_pol = 0, out_ready = 0;
    logic [15:0] in_ts = '0;
    logic [2:0] in_x = '0, in_y = '0;
    logic in_ready, out_valid, out_bit, out_last;
    logic [7:0] drop_count;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DEPTH-1:0] exp_t [3];
    bit closes [NV];
    int win_of [NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    voxel_event_encoder u_voxel_event_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ts(in_ts), .in_x(in_x), .in_y(in_y), .in_pol(in_pol),
        .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
        .out_last(out_last), .drop_count(drop_count)
    );

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic send(int ts, int x, int y, int p);
        @(negedge clk);
        in_valid = 1; in_ts = 16'(ts); in_x = 3'(x); in_y = 3'(y); in_pol = p[0];
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    // Collect one readout and compare against window w; stall at beat 10.
    task automatic collect(int w);
        logic held;
        do begin @(negedge clk); #1; end while (!out_valid);
        for (int b = 0; b < DEPTH; b++) begin
            check(out_valid, "R6 beat valid", int'(out_valid), 1);
            check(!in_ready, "R8 input blocked", int'(in_ready), 0);
            check(out_bit == exp_t[w][b], (w == 0) ? "R2 R4 voxel" : "R5 R9 voxel",
                  int'(out_bit), int'(exp_t[w][b]));
            check(out_last == (b == DEPTH-1), "R6 last flag", int'(out_last),
                  int'(b == DEPTH-1));
            if (b == 10) begin
                out_ready = 0; held = out_bit;
                for (int k = 0; k < 3; k++) begin
                    @(posedge clk); @(negedge clk); #1;
                    check(out_valid && out_bit == held, "R8 stall hold",
                          int'(out_bit), int'(held));
                end
            end
            out_ready = 1;
            @(posedge clk); #1;
            out_ready = 0;
            if (b != DEPTH-1) begin @(negedge clk); #1; end
        end
        @(negedge clk); #1;
        check(!out_valid, "R6 drain ends", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int cur_start, w;
        // Expected model from the requirements.
        for (int i = 0; i < 3; i++) exp_t[i] = '0;
        cur_start = -1; w = -1;
        for (int i = 0; i < NV; i++) begin
            closes[i] = 0; win_of[i] = -1;
            if (V_X[i] < 4 && V_Y[i] < 4) begin
                if (cur_start < 0 || V_TS[i] - cur_start >= 16) begin
                    closes[i] = (cur_start >= 0);
                    w++; cur_start = V_TS[i] & ~15;
                end
                win_of[i] = w;
                exp_t[w][(((V_TS[i] - cur_start) / 4 * 2 + V_P[i]) * 4 + V_Y[i]) * 4
                         + V_X[i]] = 1'b1;
            end
        end

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        check(in_ready, "R1 in_ready", int'(in_ready), 1);
        check(!out_valid, "R1 out_valid", int'(out_valid), 0);
        check(drop_count == 0, "R1 drop_count", int'(drop_count), 0);

        // Walk the table; closing events run alongside the readout (R3, R5).
        for (int i = 0; i < NV; i++) begin
            if (closes[i]) begin
                fork
                    send(V_TS[i], V_X[i], V_Y[i], V_P[i]);
                    collect(win_of[i] - 1);
                join
            end else begin
                send(V_TS[i], V_X[i], V_Y[i], V_P[i]);
                @(negedge clk); #1;
                check(!out_valid, "R7 no spurious close", int'(out_valid), 0);
            end
        end
        check(drop_count == 2, "R7 drop count", int'(drop_count), 2);

        // R7 saturation of the drop counter.
        for (int i = 0; i < 260; i++) send(300, 7, 1, 0);
        @(negedge clk); #1;
        check(drop_count == 255, "R7 saturation", int'(drop_count), 255);
        check(!out_valid, "R7 drops keep window", int'(out_valid), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule